// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block looks at a window of six instruction bytes taken from an aligned prefetch buffer and works out how many of them form the instruction that starts at the lowest byte. The opcode sits in the lowest byte, at bits 7:0 of the window. The length is built from four parts: the opcode byte, an optional operand-specifier byte, a displacement, and an immediate. The size of the displacement depends on the specifier's mode and register-or-memory fields. The size of the immediate depends on the opcode.

Besides the length, the block hands the fetch and decode stages the fields they need: the opcode, the three fields of the specifier byte, a 16-bit displacement and a 16-bit immediate. It also gives a valid strobe one cycle after a window is presented. The covered set is the one-byte no-op, the one-byte register increment, the four register/memory add forms, and the immediate-arithmetic group in three variants. Any other opcode is flagged illegal and is given length 1, so the fetch unit can always step forward.

Top module: `insn_len_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero.
- R2: `dec_valid_o` is high in the cycle after a clock edge that sampled `win_valid_i` high, and low after an edge that sampled it low. All other outputs change only when a window is accepted.
- R3: Opcode 0x90 and opcodes 0x40 to 0x47 give length 1, no specifier, and zero displacement and immediate. For 0x40 to 0x47, `reg_o` carries the opcode's low three bits. For 0x90, `reg_o` is 0.
- R4: For opcodes 0x00 to 0x03, 0x80, 0x81 and 0x83, the second byte is the specifier: `mode_o` is its bits 7:6, `reg_o` its bits 5:3 and `rm_o` its bits 2:0. When there is no specifier, `mode_o` and `rm_o` are 0.
- R5: Mode 3, and mode 0 with r/m other than 6, add no displacement bytes, and `disp_o` is 0.
- R6: Mode 0 with r/m 6 adds two displacement bytes. Byte 2 is the low half and byte 3 the high half.
- R7: Mode 1 adds one displacement byte (byte 2), sign-extended to 16 bits.
- R8: Mode 2 adds two displacement bytes in the same little-endian order as R6.
- R9: The immediate starts right after any displacement. Opcode 0x81 takes two bytes, little-endian. Opcode 0x80 takes one byte, zero-extended. Opcode 0x83 takes one byte, sign-extended. Opcodes 0x00 to 0x03 carry no immediate, and `imm_o` is 0 for them.
- R10: Any other opcode sets `illegal_o`, gives length 1, and gives zero for `has_spec_o`, mode, reg, r/m, displacement and immediate.
- R11: When `dec_valid_o` is high, `len_o` is 1 + specifier + displacement + immediate bytes. It always lies between 1 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_valid_i | input | 1 | Window present this cycle |
| win_bytes_i | input | 48 | Six instruction bytes; byte k in bits 8k+7:8k |
| dec_valid_o | output | 1 | Decoded results valid |
| len_o | output | 3 | Instruction length in bytes |
| illegal_o | output | 1 | Opcode outside the covered set |
| opcode_o | output | 8 | First byte of the window |
| has_spec_o | output | 1 | Specifier byte present |
| mode_o | output | 2 | Specifier mode field |
| reg_o | output | 3 | Register field (specifier, or increment opcode) |
| rm_o | output | 3 | Register-or-memory field |
| disp_o | output | 16 | Displacement, sign-extended when one byte |
| imm_o | output | 16 | Immediate, extended per opcode |

## Verification
Fixed windows cover each length from 1 to 6. These include:
- the direct-address case against mode 0 with other r/m values, which separates the r/m 6 exception from plain indirect addressing;
- negative one-byte displacements and immediates, which separate sign extension (0x83, mode 1) from zero extension (0x80);
- a mode-2 word displacement followed by a word immediate, which checks where the immediate starts and reaches the largest length.

Illegal opcodes, idle cycles between windows, and a long run of mixed windows with random specifier and operand bytes are all compared every clock against a behavioural model.

// File: rtl/ild_pkg.sv
// Shared opcode constants and classification types for the length decoder.
// Assumes 8-bit bytes; the constants are the covered opcode values.
package ild_pkg;

    localparam logic [7:0] OP_NOP     = 8'h90;
    localparam logic [4:0] OP_INC_TOP = 5'b01000;   // 0x40..0x47
    localparam logic [5:0] OP_ADD_TOP = 6'b000000;  // 0x00..0x03
    localparam logic [7:0] OP_GRP_B   = 8'h80;
    localparam logic [7:0] OP_GRP_W   = 8'h81;
    localparam logic [7:0] OP_GRP_SX  = 8'h83;

    typedef enum logic [1:0] {
        IMM_NONE   = 2'd0,
        IMM_BYTE_Z = 2'd1,
        IMM_BYTE_S = 2'd2,
        IMM_WORD   = 2'd3
    } imm_kind_e;

    typedef struct packed {
        logic      illegal;
        logic      has_spec;
        logic      inc_form;
        imm_kind_e imm_kind;
    } op_class_t;

endpackage

// File: rtl/ild_opcode_class.sv
// Classifies the first window byte: legal or not, whether a specifier byte
// follows, whether it is a register increment, and the immediate kind.
// Assumes no prefixes; the first byte is always the opcode.
module ild_opcode_class
    import ild_pkg::*;
(
    input  logic [7:0] opcode_i,
    output op_class_t  cls_o
);

    // Opcode lookup over the covered set; everything else is illegal.
    always_comb begin
        cls_o = '{illegal: 1'b1, has_spec: 1'b0, inc_form: 1'b0, imm_kind: IMM_NONE};
        if (opcode_i == OP_NOP) begin
            cls_o.illegal = 1'b0;
        end else if (opcode_i[7:3] == OP_INC_TOP) begin
            cls_o.illegal  = 1'b0;
            cls_o.inc_form = 1'b1;
        end else if (opcode_i[7:2] == OP_ADD_TOP) begin
            cls_o.illegal  = 1'b0;
            cls_o.has_spec = 1'b1;
        end else if (opcode_i == OP_GRP_B) begin
            cls_o.illegal  = 1'b0;
            cls_o.has_spec = 1'b1;
            cls_o.imm_kind = IMM_BYTE_Z;
        end else if (opcode_i == OP_GRP_W) begin
            cls_o.illegal  = 1'b0;
            cls_o.has_spec = 1'b1;
            cls_o.imm_kind = IMM_WORD;
        end else if (opcode_i == OP_GRP_SX) begin
            cls_o.illegal  = 1'b0;
            cls_o.has_spec = 1'b1;
            cls_o.imm_kind = IMM_BYTE_S;
        end
    end

endmodule

// File: rtl/ild_spec_split.sv
// Splits the specifier byte into mode, reg and r/m fields and derives the
// number of displacement bytes. Outputs are zero when no specifier exists.
module ild_spec_split #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] spec_i,
    input  logic              present_i,
    output logic [1:0]        mode_o,
    output logic [2:0]        reg_o,
    output logic [2:0]        rm_o,
    output logic [1:0]        disp_len_o
);

    localparam logic [2:0] RM_DIRECT = 3'd6;

    // Field extraction, gated by specifier presence.
    always_comb begin
        mode_o = '0;
        reg_o  = '0;
        rm_o   = '0;
        if (present_i) begin
            mode_o = spec_i[7:6];
            reg_o  = spec_i[5:3];
            rm_o   = spec_i[2:0];
        end
    end

    // Displacement size from mode, with the direct-address exception.
    always_comb begin
        disp_len_o = 2'd0;
        if (present_i) begin
            case (mode_o)
                2'd1:    disp_len_o = 2'd1;
                2'd2:    disp_len_o = 2'd2;
                2'd0:    disp_len_o = (rm_o == RM_DIRECT) ? 2'd2 : 2'd0;
                default: disp_len_o = 2'd0;
            endcase
        end
    end

endmodule

// File: rtl/ild_operand_pick.sv
// Picks displacement and immediate bytes out of the window and extends them
// to a word. Assumes the displacement always starts at byte 2 and the
// immediate right after the displacement.
module ild_operand_pick
    import ild_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int WIN_BYTES = 6
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    input  logic                        has_spec_i,
    input  logic [1:0]                  disp_len_i,
    input  imm_kind_e                   imm_kind_i,
    output logic [2*BYTE_W-1:0]         disp_o,
    output logic [2*BYTE_W-1:0]         imm_o,
    output logic [1:0]                  imm_len_o
);

    localparam int IDX_W    = $clog2(WIN_BYTES + 1);
    localparam int DISP_IDX = 2;

    logic [BYTE_W-1:0] win_b [WIN_BYTES];
    logic [IDX_W-1:0]  imm_idx;
    logic [BYTE_W-1:0] imm_lo;
    logic [BYTE_W-1:0] imm_hi;

    genvar gi;
    generate
        for (gi = 0; gi < WIN_BYTES; gi++) begin : g_unpack
            assign win_b[gi] = win_i[gi*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Displacement: one byte sign-extended, or two bytes low-first.
    always_comb begin
        case (disp_len_i)
            2'd1:    disp_o = {{BYTE_W{win_b[DISP_IDX][BYTE_W-1]}}, win_b[DISP_IDX]};
            2'd2:    disp_o = {win_b[DISP_IDX+1], win_b[DISP_IDX]};
            default: disp_o = '0;
        endcase
    end

    // Immediate starts after opcode, specifier and displacement.
    assign imm_idx = IDX_W'(1) + IDX_W'(has_spec_i) + IDX_W'(disp_len_i);

    // Byte selection at the immediate position without out-of-range indexing.
    always_comb begin
        imm_lo = '0;
        imm_hi = '0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (IDX_W'(i) == imm_idx)         imm_lo = win_b[i];
            if (IDX_W'(i) == imm_idx + 1'b1)  imm_hi = win_b[i];
        end
    end

    // Immediate extension and size by kind.
    always_comb begin
        case (imm_kind_i)
            IMM_BYTE_Z: begin imm_o = {{BYTE_W{1'b0}}, imm_lo};         imm_len_o = 2'd1; end
            IMM_BYTE_S: begin imm_o = {{BYTE_W{imm_lo[BYTE_W-1]}}, imm_lo}; imm_len_o = 2'd1; end
            IMM_WORD:   begin imm_o = {imm_hi, imm_lo};                 imm_len_o = 2'd2; end
            default:    begin imm_o = '0;                               imm_len_o = 2'd0; end
        endcase
    end

endmodule

// File: rtl/insn_len_decoder.sv
// Top of the instruction length decoder. Combines opcode class, specifier
// split and operand pick, then registers all results one cycle after a
// window is accepted. Assumes the window holds the whole instruction.
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int WIN_BYTES = 6,
    localparam int LEN_W    = $clog2(WIN_BYTES + 1),
    localparam int WORD_W   = 2 * BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_valid_i,
    input  logic [WIN_BYTES*BYTE_W-1:0] win_bytes_i,
    output logic                        dec_valid_o,
    output logic [LEN_W-1:0]            len_o,
    output logic                        illegal_o,
    output logic [BYTE_W-1:0]           opcode_o,
    output logic                        has_spec_o,
    output logic [1:0]                  mode_o,
    output logic [2:0]                  reg_o,
    output logic [2:0]                  rm_o,
    output logic [WORD_W-1:0]           disp_o,
    output logic [WORD_W-1:0]           imm_o
);

    op_class_t         cls;
    logic [1:0]        mode_d;
    logic [2:0]        spec_reg_d;
    logic [2:0]        rm_d;
    logic [1:0]        disp_len;
    logic [1:0]        imm_len;
    logic [WORD_W-1:0] disp_d;
    logic [WORD_W-1:0] imm_d;
    logic [2:0]        reg_d;
    logic [LEN_W-1:0]  len_d;

    ild_opcode_class u_class (
        .opcode_i (win_bytes_i[BYTE_W-1:0]),
        .cls_o    (cls)
    );

    ild_spec_split #(.BYTE_W(BYTE_W)) u_split (
        .spec_i     (win_bytes_i[2*BYTE_W-1:BYTE_W]),
        .present_i  (cls.has_spec),
        .mode_o     (mode_d),
        .reg_o      (spec_reg_d),
        .rm_o       (rm_d),
        .disp_len_o (disp_len)
    );

    ild_operand_pick #(.BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES)) u_pick (
        .win_i      (win_bytes_i),
        .has_spec_i (cls.has_spec),
        .disp_len_i (disp_len),
        .imm_kind_i (cls.imm_kind),
        .disp_o     (disp_d),
        .imm_o      (imm_d),
        .imm_len_o  (imm_len)
    );

    // Register field: from the increment opcode or from the specifier.
    assign reg_d = cls.inc_form ? win_bytes_i[2:0] : spec_reg_d;

    // Total length; illegal opcodes advance by one byte.
    assign len_d = cls.illegal ? LEN_W'(1)
                 : LEN_W'(1) + LEN_W'(cls.has_spec) + LEN_W'(disp_len) + LEN_W'(imm_len);

    // Valid strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dec_valid_o <= 1'b0;
        else        dec_valid_o <= win_valid_i;
    end

    // Result registers load only when a window is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_o      <= '0;
            illegal_o  <= 1'b0;
            opcode_o   <= '0;
            has_spec_o <= 1'b0;
            mode_o     <= '0;
            reg_o      <= '0;
            rm_o       <= '0;
            disp_o     <= '0;
            imm_o      <= '0;
        end else if (win_valid_i) begin
            len_o      <= len_d;
            illegal_o  <= cls.illegal;
            opcode_o   <= win_bytes_i[BYTE_W-1:0];
            has_spec_o <= cls.has_spec;
            mode_o     <= mode_d;
            reg_o      <= reg_d;
            rm_o       <= rm_d;
            disp_o     <= disp_d;
            imm_o      <= imm_d;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_i |=> dec_valid_o);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_i |=> (!dec_valid_o && $stable(len_o) && $stable(opcode_o)));

    // R11
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (len_o >= LEN_W'(1) && len_o <= LEN_W'(WIN_BYTES)));

    // R10
    illegal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && illegal_o) |-> (len_o == LEN_W'(1) && !has_spec_o && imm_o == '0));

    // R5
    no_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && has_spec_o && (mode_o == 2'd3 || (mode_o == 2'd0 && rm_o != 3'd6)))
        |-> (disp_o == '0));

    // R7
    disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && has_spec_o && mode_o == 2'd1)
        |-> (disp_o[WORD_W-1:BYTE_W] == {BYTE_W{disp_o[BYTE_W-1]}}));

    // R9
    imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && opcode_o == OP_GRP_SX)
        |-> (imm_o[WORD_W-1:BYTE_W] == {BYTE_W{imm_o[BYTE_W-1]}}));

endmodule

// File: tb/insn_len_decoder_bench.sv
module insn_len_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_valid_i = 1'b0;
    logic [47:0] win_bytes_i = '0;
    logic        dec_valid_o;
    logic [2:0]  len_o;
    logic        illegal_o;
    logic [7:0]  opcode_o;
    logic        has_spec_o;
    logic [1:0]  mode_o;
    logic [2:0]  reg_o;
    logic [2:0]  rm_o;
    logic [15:0] disp_o;
    logic [15:0] imm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state for the window applied at the previous falling edge
    bit    exp_armed = 0;
    bit    exp_vld;
    int    e_len, e_ill, e_op, e_hs, e_mode, e_reg, e_rm, e_disp, e_imm;
    string e_tag;

    always #2 clk = ~clk;

    insn_len_decoder u_insn_len_decoder (
        .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid_i), .win_bytes_i(win_bytes_i),
        .dec_valid_o(dec_valid_o), .len_o(len_o), .illegal_o(illegal_o),
        .opcode_o(opcode_o), .has_spec_o(has_spec_o), .mode_o(mode_o), .reg_o(reg_o),
        .rm_o(rm_o), .disp_o(disp_o), .imm_o(imm_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one window
    task automatic model(logic [47:0] w, string tag);
        int b[6];
        int kind;
        int dl;
        int p;
        for (int i = 0; i < 6; i++) b[i] = int'(w[i*8 +: 8]);
        e_op = b[0]; e_ill = 1; e_hs = 0; kind = 0;
        e_mode = 0; e_reg = 0; e_rm = 0; e_disp = 0; e_imm = 0; dl = 0;
        if (b[0] == 'h90) e_ill = 0;
        else if (b[0] >= 'h40 && b[0] <= 'h47) begin e_ill = 0; e_reg = b[0] % 8; end
        else if (b[0] <= 3) begin e_ill = 0; e_hs = 1; end
        else if (b[0] == 'h80) begin e_ill = 0; e_hs = 1; kind = 1; end
        else if (b[0] == 'h81) begin e_ill = 0; e_hs = 1; kind = 3; end
        else if (b[0] == 'h83) begin e_ill = 0; e_hs = 1; kind = 2; end
        if (e_hs == 1) begin
            e_mode = b[1] / 64; e_reg = (b[1] / 8) % 8; e_rm = b[1] % 8;
            if (e_mode == 1) dl = 1;
            else if (e_mode == 2 || (e_mode == 0 && e_rm == 6)) dl = 2;
        end
        if (dl == 1) e_disp = (b[2] >= 128) ? b[2] + 'hFF00 : b[2];
        if (dl == 2) e_disp = b[2] + 256 * b[3];
        p = 1 + e_hs + dl;
        e_len = p;
        if (kind == 1) begin e_imm = b[p]; e_len = p + 1; end
        if (kind == 2) begin e_imm = (b[p] >= 128) ? b[p] + 'hFF00 : b[p]; e_len = p + 1; end
        if (kind == 3) begin e_imm = b[p] + 256 * b[p+1]; e_len = p + 2; end
        if (e_ill == 1) e_len = 1;
        e_tag = tag;
    endtask

    task automatic compare();
        if (!exp_armed) return;
        if (!exp_vld) begin
            chk("R2", "dec_valid idle", int'(dec_valid_o), 0);
            return;
        end
        chk("R2", "dec_valid", int'(dec_valid_o), 1);
        chk(e_tag, "len", int'(len_o), e_len);
        chk(e_tag, "illegal", int'(illegal_o), e_ill);
        chk(e_tag, "opcode", int'(opcode_o), e_op);
        chk(e_tag, "has_spec", int'(has_spec_o), e_hs);
        chk(e_tag, "mode", int'(mode_o), e_mode);
        chk(e_tag, "reg", int'(reg_o), e_reg);
        chk(e_tag, "rm", int'(rm_o), e_rm);
        chk(e_tag, "disp", int'(disp_o), e_disp);
        chk(e_tag, "imm", int'(imm_o), e_imm);
        chk("R11", "len range", int'(len_o >= 1 && len_o <= 6), 1);
    endtask

    // compare the previous window, then present the next one
    task automatic step(bit v, logic [47:0] w, string tag);
        @(negedge clk);
        compare();
        win_valid_i = v;
        win_bytes_i = w;
        exp_armed = 1;
        exp_vld = v;
        if (v) model(w, tag);
    endtask

    // pack bytes low-first
    function automatic logic [47:0] pk(int b0, int b1 = 0, int b2 = 0, int b3 = 0, int b4 = 0, int b5 = 0);
        return {8'(b5), 8'(b4), 8'(b3), 8'(b2), 8'(b1), 8'(b0)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero while in reset
        chk("R1", "dec_valid in reset", int'(dec_valid_o), 0);
        chk("R1", "len in reset", int'(len_o), 0);
        chk("R1", "disp/imm in reset", int'(disp_o | imm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dec_valid after reset", int'(dec_valid_o), 0);
        chk("R1", "opcode after reset", int'(opcode_o), 0);

        step(1, pk('h90, 'h11, 'h22), "R3");
        step(1, pk('h43, 'hFF), "R3");
        step(1, pk('h01, 'hC3, 'h55), "R4 R5");
        step(1, pk('h02, 'h07, 'h99, 'h99), "R5");
        step(1, pk('h03, 'h1E, 'h01, 'h00), "R6");
        step(0, pk('h81, 'h86), "R2");
        step(1, pk('h02, 'h47, 'hF0, 'h77), "R7");
        step(1, pk('h00, 'h87, 'h34, 'h12, 'hAA), "R8");
        step(1, pk('h81, 'h40, 'h02, 'h01, 'h00), "R9");
        step(1, pk('h80, 'hC3, 'hF1, 'h22), "R9");
        step(1, pk('h83, 'hC3, 'hFF, 'h22), "R9");
        step(1, pk('h83, 'h06, 'h10, 'h20, 'h85), "R6 R9");
        step(1, pk('h81, 'h86, 'h78, 'h56, 'h34, 'h12), "R8 R9 R11");
        step(1, pk('h0F, 'hC3, 'h01), "R10");
        step(1, pk('h48, 'h00), "R10");
        step(0, pk(0), "R2");
        step(0, pk(0), "R2");
        step(1, pk('h80, 'h41, 'h80, 'h7F), "R7 R9");

        for (int n = 0; n < 400; n++) begin
            int sel;
            int ops[8] = '{'h90, 'h45, 'h00, 'h03, 'h80, 'h81, 'h83, 'hC7};
            logic [47:0] w;
            sel = int'($urandom % 8);
            w = {$urandom, $urandom};
            w[7:0] = 8'(ops[sel]);
            step(($urandom % 5) != 0, w, "R11");
        end
        step(0, pk(0), "R2");
        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule